// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a key matrix by raising one row line at a time and sampling the column lines that come back. Each row stays active for a window whose length is sixteen cycles plus a programmable debounce count. A short idle gap precedes the first row of every pass. Each row's column pattern is accepted only if it has held steady long enough inside its window. Otherwise the row keeps its last accepted pattern.

At the end of a pass, every pressed key is turned into an eight-bit entry. Up to eight entries make up one frame, and the frame goes into a small frame queue if any key was down. Software reaches the block through a word-addressed register port with a control word, an interrupt status word, two packed entry words and one key-mask word per row. Reading the upper entry word retires the oldest frame.

Two interrupt causes exist, each cleared by writing one. The first is a queue-threshold cause, raised when a stored frame brings the pending count up to a programmed level. The second is a keypress cause, raised when a pressed key's mask bit is clear. The row and column counts and the queue depth are parameters.

Top module: `keypad_scan`

## Requirements
- R1: After reset, all row outputs are low, the interrupt output is low, and the control word, status word and both entry words read as zero.
- R2: While enabled, at most one row output is high. Each row is high for 16 + debounce cycles, rows run in ascending order, and a gap of exactly 5 cycles with no row high precedes each pass.
- R3: A key entry is bit 7 = 1 (valid), bits 6:3 = row, bits 2:0 = column. Entries are ordered by row and then by column, ascending. Entry k sits in byte k mod 4 of the lower entry word (address 0x08) for k < 4, and of the upper entry word (address 0x0C) otherwise. Keys beyond the eighth in a pass are left out.
- R4: Status (address 0x04) bits 7:4 give the pending frame count. A read of address 0x0C removes the oldest frame. With no frame pending, both entry words read zero.
- R5: The queue holds at most 8 frames. A frame completed while the queue is full is discarded.
- R6: Control (address 0x00) bits 17:14 set the threshold. Status bit 2 is set when a frame is stored and the new pending count is at least a non-zero threshold. Writing 1 to status bit 2 clears it.
- R7: Status bit 0 is set when an accepted pressed key has its mask bit clear. The mask word for row r is at address 0x10 + 4r, with bit c covering column c. Keys whose mask bit is set still produce entries. Writing 1 to status bit 0 clears it.
- R8: The interrupt output equals (status bit 2 AND control bit 3) OR (status bit 0 AND control bit 1).
- R9: Control bits 13:4 hold the debounce count. A column pattern that keeps changing within a row window is rejected when the debounce count is non-zero, and that row then reports its previously accepted state.
- R10: Clearing control bit 0 stops the scan, drives all rows low, empties the queue and discards partial frames.
- R11: A pass that finds no pressed key stores no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on upper entry word) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| row_o | output | ROWS | Row drive, active high, one-hot or zero |
| col_i | input | COLS | Column sense, high means key closed on the active row |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A broken pass sequencer appears on the row pins within one row window: a row high for the wrong number of cycles, two rows high together, or a gap of other than five idle cycles. A wrong frame builder or queue pointer appears at the first entry-word read after the next pass ends, within one pass of roughly 261 cycles at zero debounce. It shows as misordered bytes, missing valid bits, a ninth entry or stale frames. Faulty flag logic shows in the status word and the interrupt pin right after the push or the clearing write that should have moved it.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;
    localparam int ENTRY_W    = 8;
    localparam int FRAME_KEYS = 8;
    localparam int FRAME_W    = ENTRY_W * FRAME_KEYS;
    localparam int SETTLE_CYC = 16;
    localparam int LEAD_CYC   = 5;
    localparam int DEB_W      = 10;
    localparam int THR_W      = 4;

    localparam logic [5:0] IDX_CTRL   = 6'd0;
    localparam logic [5:0] IDX_STAT   = 6'd1;
    localparam logic [5:0] IDX_ENT_LO = 6'd2;
    localparam logic [5:0] IDX_ENT_HI = 6'd3;
    localparam logic [5:0] IDX_MASK0  = 6'd4;

    typedef enum logic { PH_LEAD, PH_ROW } phase_e;

    function automatic logic [ENTRY_W-1:0] make_entry(input logic [3:0] r, input logic [2:0] c);
        return {1'b1, r, c};
    endfunction
endpackage

// File: rtl/keypad_seq.sv
module keypad_seq
    import keypad_scan_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [DEB_W-1:0]        deb,
    output logic [$clog2(ROWS)-1:0] row_idx,
    output logic                    in_row,
    output logic                    row_first,
    output logic                    row_last,
    output logic                    pass_last
);
    localparam int RI_W  = $clog2(ROWS);
    localparam int CNT_W = DEB_W + 1;

    typedef struct packed {
        phase_e          ph;
        logic [CNT_W-1:0] cnt;
        logic [RI_W-1:0]  row;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] win_end;

    always_comb begin
        win_end   = CNT_W'(SETTLE_CYC) + CNT_W'(deb) - CNT_W'(1);
        in_row    = (s_q.ph == PH_ROW);
        row_first = in_row && (s_q.cnt == '0);
        row_last  = in_row && (s_q.cnt == win_end);
        pass_last = row_last && (s_q.row == RI_W'(ROWS - 1));
        row_idx   = s_q.row;
        s_d       = s_q;
        if (!run) begin
            s_d = '{PH_LEAD, '0, '0};
        end else if (s_q.ph == PH_LEAD) begin
            if (s_q.cnt == CNT_W'(LEAD_CYC - 1)) begin
                s_d = '{PH_ROW, '0, '0};
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (row_last) begin
            s_d.cnt = '0;
            if (pass_last) s_d.ph = PH_LEAD;
            else           s_d.row = s_q.row + 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{PH_LEAD, '0, '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/keypad_fifo.sv
module keypad_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [W-1:0]               head
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        do_push = push && !flush && (f_q.cnt != CW'(DEPTH));
        do_pop  = pop && !flush && (f_q.cnt != '0);
        f_d     = f_q;
        if (do_push) begin
            f_d.mem[f_q.wp] = push_data;
            f_d.wp = (f_q.wp == PW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == PW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        end
        f_d.cnt = f_q.cnt + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            f_d.wp  = '0;
            f_d.rp  = '0;
            f_d.cnt = '0;
        end
        count = f_q.cnt;
        head  = (f_q.cnt == '0) ? '0 : f_q.mem[f_q.rp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/keypad_scan.sv
module keypad_scan
    import keypad_scan_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int COLS  = 8,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic [ROWS-1:0] row_o,
    input  logic [COLS-1:0] col_i,
    output logic            irq_o
);
    localparam int RI_W = $clog2(ROWS);
    localparam int CW   = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                       en;
        logic                       kp_ie;
        logic                       fifo_ie;
        logic [DEB_W-1:0]           deb;
        logic [THR_W-1:0]           thr;
        logic                       fifo_f;
        logic                       kp_f;
        logic [ROWS-1:0][COLS-1:0]  mask;
        logic [ROWS-1:0][COLS-1:0]  held;
        logic [FRAME_W-1:0]         frame;
        logic [3:0]                 fcnt;
        logic [COLS-1:0]            col_q;
        logic [DEB_W-1:0]           stab;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [RI_W-1:0]    row_idx;
    logic               in_row, row_first, row_last, pass_last;
    logic [CW-1:0]      fifo_cnt;
    logic [FRAME_W-1:0] fifo_head;
    logic [FRAME_W-1:0] fr;
    logic [3:0]         fc;
    logic [COLS-1:0]    row_new;
    logic [5:0]         idx;
    logic               push, pop, push_ok, pop_ok;
    int                 nxt_cnt;
    int                 mi;
    logic               en_w, kp_ie_w, fifo_ie_w, pop_addr_w;
    logic               unused_bits;

    assign unused_bits = ^{bus_wdata[31:18], bus_addr[1:0]};
    assign idx         = bus_addr[7:2];
    assign mi          = int'(idx) - int'(IDX_MASK0);

    keypad_seq #(.ROWS(ROWS)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(r_q.en), .deb(r_q.deb),
        .row_idx(row_idx), .in_row(in_row), .row_first(row_first),
        .row_last(row_last), .pass_last(pass_last)
    );

    keypad_fifo #(.DEPTH(DEPTH), .W(FRAME_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!r_q.en), .push(push), .push_data(fr),
        .pop(pop), .count(fifo_cnt), .head(fifo_head)
    );

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign row_o[g] = r_q.en && in_row && (row_idx == RI_W'(g));
    end

    always_comb begin
        r_d = r_q;
        // register writes; flag clears come first so a same-cycle set wins
        if (bus_wr) begin
            if (idx == IDX_CTRL) begin
                r_d.en      = bus_wdata[0];
                r_d.kp_ie   = bus_wdata[1];
                r_d.fifo_ie = bus_wdata[3];
                r_d.deb     = bus_wdata[13:4];
                r_d.thr     = bus_wdata[17:14];
            end else if (idx == IDX_STAT) begin
                if (bus_wdata[2]) r_d.fifo_f = 1'b0;
                if (bus_wdata[0]) r_d.kp_f   = 1'b0;
            end else if (mi >= 0 && mi < ROWS) begin
                r_d.mask[RI_W'(mi)] = bus_wdata[COLS-1:0];
            end
        end
        // column stability tracking inside the active row window
        r_d.col_q = col_i;
        if (row_first || (col_i != r_q.col_q)) r_d.stab = '0;
        else if (r_q.stab != '1)               r_d.stab = r_q.stab + 1'b1;
        row_new = (r_q.stab >= r_q.deb) ? r_q.col_q : r_q.held[row_idx];
        // frame assembly
        fr = r_q.frame;
        fc = r_q.fcnt;
        if (row_last) begin
            r_d.held[row_idx] = row_new;
            for (int c = 0; c < COLS; c++) begin
                if (row_new[c] && (fc < 4'(FRAME_KEYS))) begin
                    fr[int'(fc)*ENTRY_W +: ENTRY_W] = make_entry(4'(row_idx), 3'(c));
                    fc = fc + 1'b1;
                end
            end
            if (|(row_new & ~r_q.mask[row_idx])) r_d.kp_f = 1'b1;
        end
        push = pass_last && (fc != '0);
        if (pass_last) begin
            r_d.frame = '0;
            r_d.fcnt  = '0;
        end else begin
            r_d.frame = fr;
            r_d.fcnt  = fc;
        end
        // queue bookkeeping for the threshold cause
        pop     = bus_rd && (idx == IDX_ENT_HI);
        push_ok = push && r_q.en && (fifo_cnt != CW'(DEPTH));
        pop_ok  = pop && r_q.en && (fifo_cnt != '0);
        nxt_cnt = int'(fifo_cnt) + int'(push_ok) - int'(pop_ok);
        if (push_ok && (r_q.thr != '0) && (nxt_cnt >= int'(r_q.thr))) r_d.fifo_f = 1'b1;
        // disabled: drop all scan state
        if (!r_q.en) begin
            r_d.held  = '0;
            r_d.frame = '0;
            r_d.fcnt  = '0;
            r_d.stab  = '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (idx == IDX_CTRL) begin
            bus_rdata[0]     = r_q.en;
            bus_rdata[1]     = r_q.kp_ie;
            bus_rdata[3]     = r_q.fifo_ie;
            bus_rdata[13:4]  = r_q.deb;
            bus_rdata[17:14] = r_q.thr;
        end else if (idx == IDX_STAT) begin
            bus_rdata[7:4] = 4'(fifo_cnt);
            bus_rdata[2]   = r_q.fifo_f;
            bus_rdata[0]   = r_q.kp_f;
        end else if (idx == IDX_ENT_LO) begin
            bus_rdata = fifo_head[31:0];
        end else if (idx == IDX_ENT_HI) begin
            bus_rdata = fifo_head[63:32];
        end else if (mi >= 0 && mi < ROWS) begin
            bus_rdata[COLS-1:0] = r_q.mask[RI_W'(mi)];
        end
    end

    assign irq_o      = (r_q.fifo_f && r_q.fifo_ie) || (r_q.kp_f && r_q.kp_ie);
    assign en_w       = r_q.en;
    assign kp_ie_w    = r_q.kp_ie;
    assign fifo_ie_w  = r_q.fifo_ie;
    assign pop_addr_w = (idx == IDX_ENT_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/keypad_scan_chk.sv
module keypad_scan_chk #(
    parameter int ROWS  = 16,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_o,
    input logic            irq_o,
    input logic            en,
    input logic            kp_ie,
    input logic            fifo_ie,
    input logic            bus_rd,
    input logic            is_pop_addr,
    input logic            push_ok,
    input logic [CW-1:0]   pend
);
    a_r2_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_o));

    a_r10_rows_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (row_o == '0));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= CW'(DEPTH));

    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == CW'(DEPTH)) && !bus_rd && en |=> (pend == CW'(DEPTH)) || !en);

    a_r4_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && is_pop_addr && (pend != '0) && !push_ok && en
        |=> (pend == $past(pend) - 1'b1) || !en);

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !kp_ie && !fifo_ie |-> !irq_o);
endmodule

bind keypad_scan keypad_scan_chk #(.ROWS(ROWS), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_o(row_o), .irq_o(irq_o), .en(en_w),
    .kp_ie(kp_ie_w), .fifo_ie(fifo_ie_w), .bus_rd(bus_rd),
    .is_pop_addr(pop_addr_w), .push_ok(push_ok), .pend(fifo_cnt)
);

// File: tb/keypad_scan_bench.sv
module keypad_scan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 16;
    localparam int COLS = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [ROWS-1:0] row_o;
    logic [COLS-1:0] col_i;
    logic            irq_o;

    logic [ROWS-1:0][COLS-1:0] keys = '0;
    logic bounce_en = 1'b0;
    logic bounce_v  = 1'b0;
    int   bounce_row = 7;
    int   bounce_col = 6;
    int   n_cmp = 0;
    int   n_bad = 0;

    keypad_scan u_keypad_scan (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .row_o(row_o), .col_i(col_i), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        col_i = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_o[r]) begin
                col_i = col_i | keys[r];
                if (bounce_en && r == bounce_row && bounce_v) col_i[bounce_col] = 1'b1;
            end
        end
    end

    always @(negedge clk) if (bounce_en) bounce_v <= ~bounce_v;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] cfg(input bit en, input bit kp, input bit fi,
                                        input int deb, input int thr);
        return {14'b0, 4'(thr), 10'(deb), fi, 1'b0, kp, en};
    endfunction

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_pending(input int min_cnt);
        logic [31:0] s;
        int tries = 0;
        do begin
            bus_read(8'h04, s);
            tries++;
        end while (int'(s[7:4]) < min_cnt && tries < 5000);
    endtask

    task automatic shutdown();
        keys = '0;
        bounce_en = 1'b0;
        bus_write(8'h00, 32'h0);
        bus_write(8'h04, 32'h5);
        settle(3);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rows", 32'(row_o), 32'h0);
        check("R1 irq", 32'(irq_o), 32'h0);
        bus_read(8'h00, d); check("R1 ctrl", d, 32'h0);
        bus_read(8'h04, d); check("R1 status", d, 32'h0);
        bus_read(8'h08, d); check("R1 entry lo", d, 32'h0);
        bus_read(8'h0C, d); check("R1 entry hi", d, 32'h0);
    endtask

    task automatic t_single_key();
        logic [31:0] d;
        keys[2][5] = 1'b1;
        bus_write(8'h00, cfg(1, 0, 1, 0, 1));
        wait_pending(1);
        keys = '0;
        settle(600);
        bus_read(8'h04, d);
        check("R6 threshold one flag", 32'(d[2]), 32'h1);
        check("R8 irq from threshold", 32'(irq_o), 32'h1);
        check("R4 count nonzero", 32'(d[7:4] != 0), 32'h1);
        bus_read(8'h08, d); check("R3 single entry lo", d, 32'h0000_0095);
        bus_read(8'h0C, d); check("R3 single entry hi", d, 32'h0);
        shutdown();
    endtask

    task automatic t_order();
        logic [31:0] d;
        keys[0][7] = 1'b1;
        keys[3]    = 8'h03;
        keys[1][2] = 1'b1;
        bus_write(8'h00, cfg(1, 0, 0, 0, 0));
        wait_pending(1);
        bus_read(8'h08, d); check("R3 row-major lo", d, 32'h9998_8A87);
        bus_read(8'h0C, d); check("R3 row-major hi", d, 32'h0);
        shutdown();
    endtask

    task automatic t_overflow_entries();
        logic [31:0] d;
        keys[5] = 8'hFF;
        keys[6] = 8'h03;
        bus_write(8'h00, cfg(1, 0, 0, 0, 0));
        wait_pending(1);
        bus_read(8'h08, d); check("R3 eight entries lo", d, 32'hABAA_A9A8);
        bus_read(8'h0C, d); check("R3 eight entries hi", d, 32'hAFAE_ADAC);
        shutdown();
    endtask

    task automatic t_full();
        logic [31:0] d;
        keys[9][0] = 1'b1;
        bus_write(8'h00, cfg(1, 0, 0, 0, 0));
        settle(2900);
        keys = '0;
        settle(600);
        bus_read(8'h04, d); check("R5 full count", 32'(d[7:4]), 32'd8);
        bus_read(8'h08, d); check("R5 entry lo", d, 32'h0000_00C8);
        bus_read(8'h0C, d);
        bus_read(8'h04, d); check("R4 pop count", 32'(d[7:4]), 32'd7);
        shutdown();
    endtask

    task automatic t_threshold();
        logic [31:0] d;
        keys[2][5] = 1'b1;
        bus_write(8'h00, cfg(1, 0, 1, 0, 3));
        wait_pending(1);
        bus_read(8'h04, d); check("R6 below threshold", 32'(d[2]), 32'h0);
        check("R8 irq below threshold", 32'(irq_o), 32'h0);
        wait_pending(3);
        keys = '0;
        settle(600);
        bus_read(8'h04, d); check("R6 at threshold", 32'(d[2]), 32'h1);
        check("R8 irq at threshold", 32'(irq_o), 32'h1);
        bus_write(8'h04, 32'h4);
        bus_read(8'h04, d); check("R6 cleared by write", 32'(d[2]), 32'h0);
        check("R8 irq after clear", 32'(irq_o), 32'h0);
        shutdown();
    endtask

    task automatic t_keypress();
        logic [31:0] d;
        bus_write(8'h20, 32'hFF);
        bus_read(8'h20, d); check("R7 mask readback", d, 32'hFF);
        keys[4][3] = 1'b1;
        bus_write(8'h00, cfg(1, 1, 0, 0, 0));
        wait_pending(1);
        settle(300);
        bus_read(8'h04, d); check("R7 masked no flag", 32'(d[0]), 32'h0);
        check("R7 masked no irq", 32'(irq_o), 32'h0);
        bus_read(8'h08, d); check("R7 masked still recorded", d, 32'h0000_00A3);
        keys = '0;
        keys[2][1] = 1'b1;
        settle(600);
        bus_read(8'h04, d); check("R7 unmasked flag", 32'(d[0]), 32'h1);
        check("R8 irq keypress", 32'(irq_o), 32'h1);
        bus_write(8'h00, cfg(1, 0, 0, 0, 0));
        check("R8 irq gated off", 32'(irq_o), 32'h0);
        keys = '0;
        settle(600);
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, d); check("R7 cleared by write", 32'(d[0]), 32'h0);
        bus_write(8'h20, 32'h0);
        shutdown();
    endtask

    task automatic t_debounce();
        logic [31:0] d;
        bounce_en = 1'b1;
        bus_write(8'h00, cfg(1, 0, 0, 4, 0));
        settle(1100);
        bus_read(8'h04, d); check("R9 bouncing rejected", 32'(d[7:4]), 32'h0);
        bounce_en = 1'b0;
        keys[7][6] = 1'b1;
        wait_pending(1);
        bus_read(8'h08, d); check("R9 steady accepted", d, 32'h0000_00BE);
        shutdown();
    endtask

    task automatic t_timing();
        int n;
        bus_write(8'h00, cfg(1, 0, 0, 3, 0));
        @(negedge clk);
        while (!row_o[0]) @(negedge clk);
        check("R2 first row onehot", 32'(row_o), 32'h0001);
        n = 0;
        while (row_o[0]) begin n++; @(negedge clk); end
        check("R2 row window length", 32'(n), 32'd19);
        check("R2 next row", 32'(row_o), 32'h0002);
        while (!row_o[15]) @(negedge clk);
        while (row_o[15]) @(negedge clk);
        n = 0;
        while (row_o == '0) begin n++; @(negedge clk); end
        check("R2 lead gap", 32'(n), 32'd5);
        check("R2 wraps to row 0", 32'(row_o), 32'h0001);
        shutdown();
    endtask

    task automatic t_disable();
        logic [31:0] d;
        keys[1][1] = 1'b1;
        bus_write(8'h00, cfg(1, 0, 0, 0, 0));
        wait_pending(2);
        bus_write(8'h00, cfg(0, 0, 0, 0, 0));
        settle(3);
        check("R10 rows low", 32'(row_o), 32'h0);
        bus_read(8'h04, d); check("R10 queue flushed", 32'(d[7:4]), 32'h0);
        bus_read(8'h08, d); check("R10 entry zero", d, 32'h0);
        settle(600);
        bus_read(8'h04, d); check("R10 no new frames", 32'(d[7:4]), 32'h0);
        shutdown();
    endtask

    task automatic t_idle();
        logic [31:0] d;
        bus_write(8'h00, cfg(1, 0, 0, 0, 0));
        settle(1000);
        bus_read(8'h04, d); check("R11 no frames when idle", 32'(d[7:4]), 32'h0);
        bus_read(8'h08, d); check("R4 empty entry lo", d, 32'h0);
        shutdown();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        settle(4);
        @(negedge clk);
        rst_n = 1'b1;
        settle(2);
        t_reset();
        t_single_key();
        t_order();
        t_overflow_entries();
        t_full();
        t_threshold();
        t_keypress();
        t_debounce();
        t_timing();
        t_disable();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule